// File: doc/BRIEF.md
# Ring-Replicated Shared Memory Node

This block is one station on a unidirectional ring of nodes, each of which keeps a complete private copy of a shared word-addressed memory. The host sees an ordinary synchronous RAM port. Reads are served from the local copy with one cycle of latency and never create ring traffic. A write lands in the local copy at once. The block then turns it into a packet that goes out on the ring without any host software involvement.

Packets that arrive from upstream and were sent by another node are written into the local copy at the same address. They are then passed downstream unchanged. A packet that comes back to the node that sent it is removed from the ring, so every write makes exactly one trip round the ring. After that trip, every node holds the same word at that address. A counter of writes that have gone out but not yet come back lets the host see when all of its updates have reached every node.

Top module: `ringmem_node`

## Requirements
- R1: A host write (host_en=1, host_we=1 while host_ready=1) that does not meet an inbound write is stored in local RAM at that clock edge, so a read of the same address in the next cycle returns it. The write never waits for the ring.
- R2: Each accepted host write is sent on out_pkt as {origin, addr, data}: origin in bits [45:42], address in bits [41:32] and data in bits [31:0], with origin equal to node_id. Local writes leave in the order the host issued them.
- R3: An inbound packet whose origin differs from node_id is written to local RAM at its address. When it is accepted, it is loaded unchanged into the outbound register in the next cycle.
- R4: An inbound packet whose origin equals node_id is always accepted (in_ready=1), is never forwarded, and does not change local RAM.
- R5: Host reads (host_en=1, host_we=0) return local RAM data in the next cycle and never cause an outbound packet.
- R6: When the outbound register can be loaded, a forwarded inbound packet takes it ahead of any queued local write. A packet on out_pkt is held stable while out_valid=1 and out_ready=0.
- R7: Local writes wait in an 8-entry queue. With the outbound link stalled, the host can place 9 writes: 8 in the queue and 1 in the outbound register. After that, host_ready=0 until space frees.
- R8: If a host write and a forwarded inbound write reach RAM in the same cycle, the inbound write is applied first and the host write one cycle later. host_ready is 0 in the cycle between, so for the same address the host data is what remains.
- R9: pending is 0 after reset. It rises by one each time a local packet is handed off on the outbound link (out_valid and out_ready both 1). It falls by one each time one of this node's own packets returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 4 | Static identity of this node |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 10 | Word address |
| host_wdata | input | 32 | Write data |
| host_ready | output | 1 | A host write is accepted this cycle |
| host_rdata | output | 32 | Read data, one cycle after the read |
| in_valid | input | 1 | Inbound packet present |
| in_ready | output | 1 | Inbound packet accepted |
| in_pkt | input | 46 | Inbound packet {origin, addr, data} |
| out_valid | output | 1 | Outbound packet present |
| out_ready | input | 1 | Downstream accepts outbound packet |
| out_pkt | output | 46 | Outbound packet {origin, addr, data} |
| pending | output | 8 | Local writes sent but not yet returned |

## Verification
The basic patterns are a lone host write, a foreign packet passing through, and a node's own packet coming back. Together they show that local stores, forwarding and removal are three separate paths. A run of reads with the ring idle shows that reads stay local.

A stalled outbound link with a foreign packet and queued local writes separates the forward-first order from a plain first-come order. Filling the queue pins its depth to exactly nine accepted writes.

A host write and a foreign write aimed at the same address in the same cycle leave the host value in RAM only if the inbound write goes first. The return of every own packet brings pending back to zero, which ties its count to each handoff and each return.

// File: rtl/ringmem_pkg.sv
package ringmem_pkg;
   typedef enum logic [1:0] {
      WSRC_IDLE = 2'd0,
      WSRC_LINK = 2'd1,
      WSRC_HELD = 2'd2,
      WSRC_HOST = 2'd3
   } wsrc_e;
endpackage

// File: rtl/ringmem_fifo.sv
module ringmem_fifo #(
   parameter int WIDTH = 46,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("ringmem_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [WIDTH-1:0] slots [DEPTH];
   logic [AW:0]      wr_q, rd_q;

   assign empty = (wr_q == rd_q);
   assign full  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
   assign dout  = slots[rd_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q <= '0;
         rd_q <= '0;
      end else begin
         if (push && !full) begin
            slots[wr_q[AW-1:0]] <= din;
            wr_q <= wr_q + 1'b1;
         end
         if (pop && !empty) begin
            rd_q <= rd_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ringmem_wr_arb.sv
module ringmem_wr_arb
   import ringmem_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_we,
   input  logic [ADDR_W-1:0] link_addr,
   input  logic [DATA_W-1:0] link_data,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_data,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_data,
   output logic              held
);
   logic              hold_v;
   logic [ADDR_W-1:0] hold_a;
   logic [DATA_W-1:0] hold_d;
   wsrc_e             sel;

   always_comb begin
      if (link_we)      sel = WSRC_LINK;
      else if (hold_v)  sel = WSRC_HELD;
      else if (host_we) sel = WSRC_HOST;
      else              sel = WSRC_IDLE;
   end

   always_comb begin
      ram_we   = (sel != WSRC_IDLE);
      ram_addr = host_addr;
      ram_data = host_data;
      case (sel)
         WSRC_LINK: begin ram_addr = link_addr; ram_data = link_data; end
         WSRC_HELD: begin ram_addr = hold_a;    ram_data = hold_d;    end
         default:   ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
         hold_a <= '0;
         hold_d <= '0;
      end else if (host_we && (link_we || hold_v)) begin
         hold_v <= 1'b1;
         hold_a <= host_addr;
         hold_d <= host_data;
      end else if (sel == WSRC_HELD) begin
         hold_v <= 1'b0;
      end
   end

   assign held = hold_v;
endmodule

// File: rtl/ringmem_ram.sv
module ringmem_ram #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter bit RD_NEW = 1'b1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [WORDS];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   generate
      if (RD_NEW) begin : g_rd_new
         always_ff @(posedge clk) begin
            if (re) rdata <= (we && waddr == raddr) ? wdata : cells[raddr];
         end
      end else begin : g_rd_old
         always_ff @(posedge clk) begin
            if (re) rdata <= cells[raddr];
         end
      end
   endgenerate
endmodule

// File: rtl/ringmem_node.sv
module ringmem_node #(
   parameter int ID_W       = 4,
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 8,
   parameter int PEND_W     = 8,
   parameter bit RD_NEW     = 1'b1,
   localparam int PKT_W     = ID_W + ADDR_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ID_W-1:0]   node_id,
   input  logic              host_en,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_ready,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [PKT_W-1:0]  in_pkt,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [PKT_W-1:0]  out_pkt,
   output logic [PEND_W-1:0] pending
);
   generate
      if (PEND_W <= $clog2(FIFO_DEPTH + 1)) begin : g_bad_pend
         $error("ringmem_node: PEND_W too narrow for FIFO_DEPTH");
      end
      if (ID_W < 1 || ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ringmem_node: widths must be positive");
      end
   endgenerate

   logic [ID_W-1:0]   in_origin;
   logic [ADDR_W-1:0] in_addr;
   logic [DATA_W-1:0] in_data;
   logic              in_own, in_take, fwd, own_ret, out_load;
   logic              host_wr, fifo_pop, fifo_empty, fifo_full, arb_held;
   logic [PKT_W-1:0]  fifo_dout;
   logic              ram_we;
   logic [ADDR_W-1:0] ram_addr;
   logic [DATA_W-1:0] ram_data;
   logic              sent_own;
   logic              out_v_q;
   logic [PKT_W-1:0]  out_p_q;
   logic [PEND_W-1:0] pend_q;

   assign in_origin = in_pkt[PKT_W-1 -: ID_W];
   assign in_addr   = in_pkt[DATA_W +: ADDR_W];
   assign in_data   = in_pkt[DATA_W-1:0];

   assign out_load  = !out_v_q || out_ready;
   assign in_own    = (in_origin == node_id);
   assign in_ready  = in_own || out_load;
   assign in_take   = in_valid && in_ready;
   assign fwd       = in_take && !in_own;
   assign own_ret   = in_take && in_own;

   assign host_ready = !fifo_full && !arb_held;
   assign host_wr    = host_en && host_we && host_ready;
   assign fifo_pop   = out_load && !fwd && !fifo_empty;

   ringmem_fifo #(.WIDTH(PKT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (host_wr),
      .din   ({node_id, host_addr, host_wdata}),
      .pop   (fifo_pop),
      .dout  (fifo_dout),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   ringmem_wr_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_we   (fwd),
      .link_addr (in_addr),
      .link_data (in_data),
      .host_we   (host_wr),
      .host_addr (host_addr),
      .host_data (host_wdata),
      .ram_we    (ram_we),
      .ram_addr  (ram_addr),
      .ram_data  (ram_data),
      .held      (arb_held)
   );

   ringmem_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_NEW(RD_NEW)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (ram_addr),
      .wdata (ram_data),
      .re    (host_en && !host_we),
      .raddr (host_addr),
      .rdata (host_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_v_q <= 1'b0;
         out_p_q <= '0;
      end else if (out_load) begin
         out_v_q <= fwd || !fifo_empty;
         out_p_q <= fwd ? in_pkt : fifo_dout;
      end
   end

   assign sent_own = out_v_q && out_ready && (out_p_q[PKT_W-1 -: ID_W] == node_id);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         case ({sent_own, own_ret && (pend_q != '0)})
            2'b10:   pend_q <= pend_q + 1'b1;
            2'b01:   pend_q <= pend_q - 1'b1;
            default: ;
         endcase
      end
   end

   assign out_valid = out_v_q;
   assign out_pkt   = out_p_q;
   assign pending   = pend_q;
endmodule

// File: rtl/ringmem_node_chk.sv
module ringmem_node_chk #(
   parameter int ID_W   = 4,
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int PEND_W = 8,
   localparam int PKT_W = ID_W + ADDR_W + DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ID_W-1:0]   node_id,
   input logic              host_en,
   input logic              host_we,
   input logic              host_ready,
   input logic              in_valid,
   input logic              in_ready,
   input logic [PKT_W-1:0]  in_pkt,
   input logic              out_valid,
   input logic              out_ready,
   input logic [PKT_W-1:0]  out_pkt,
   input logic [PEND_W-1:0] pending
);
   logic own_in, foreign_acc, own_acc, own_sent;
   assign own_in      = (in_pkt[PKT_W-1 -: ID_W] == node_id);
   assign foreign_acc = in_valid && in_ready && !own_in;
   assign own_acc     = in_valid && in_ready && own_in;
   assign own_sent    = out_valid && out_ready && (out_pkt[PKT_W-1 -: ID_W] == node_id);

   // R3: foreign packet appears unchanged on the outbound link next cycle
   a_r3_forward_exact: assert property (@(posedge clk) disable iff (!rst_n)
      foreign_acc |=> (out_valid && out_pkt == $past(in_pkt)));

   // R4: own packets are never refused
   a_r4_own_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && own_in) |-> in_ready);

   // R6: stalled outbound packet is held
   a_r6_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_pkt)));

   // R8: a collision blocks the host port for the following cycle
   a_r8_collide_block: assert property (@(posedge clk) disable iff (!rst_n)
      (host_en && host_we && host_ready && foreign_acc) |=> !host_ready);

   // R9: pending counts handoffs and returns
   a_r9_pending_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (own_sent && !own_acc) |=> pending == $past(pending) + 1'b1);

   a_r9_pending_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (own_acc && !own_sent && pending != '0) |=> pending == $past(pending) - 1'b1);
endmodule

bind ringmem_node ringmem_node_chk #(
   .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PEND_W(PEND_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .node_id(node_id),
   .host_en(host_en), .host_we(host_we), .host_ready(host_ready),
   .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt),
   .out_valid(out_valid), .out_ready(out_ready), .out_pkt(out_pkt),
   .pending(pending)
);

// File: tb/ringmem_node_tb.sv
module ringmem_node_tb;
   localparam int ID_W = 4, ADDR_W = 10, DATA_W = 32, PEND_W = 8;
   localparam int PKT_W = ID_W + ADDR_W + DATA_W;
   localparam logic [ID_W-1:0] ME = 4'h5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_en = 1'b0, host_we = 1'b0;
   logic [ADDR_W-1:0] host_addr = '0;
   logic [DATA_W-1:0] host_wdata = '0;
   logic              host_ready;
   logic [DATA_W-1:0] host_rdata;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [PKT_W-1:0]  in_pkt = '0;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [PKT_W-1:0]  out_pkt;
   logic [PEND_W-1:0] pending;

   int vectors = 0, miscompares = 0, cyc = 0;

   always #5 clk = ~clk;

   ringmem_node u_dut (
      .clk(clk), .rst_n(rst_n), .node_id(ME),
      .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
      .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt),
      .out_valid(out_valid), .out_ready(out_ready), .out_pkt(out_pkt),
      .pending(pending)
   );

   function automatic logic [PKT_W-1:0] mk(input logic [ID_W-1:0] o,
                                           input logic [ADDR_W-1:0] a,
                                           input logic [DATA_W-1:0] d);
      return {o, a, d};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic host_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
      step();
      host_en = 1'b0; host_we = 1'b0;
   endtask

   task automatic host_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
      host_en = 1'b1; host_we = 1'b0; host_addr = a;
      step();
      host_en = 1'b0;
      d = host_rdata;
   endtask

   task automatic take_out(output logic [PKT_W-1:0] p);
      for (int i = 0; i < 50 && !out_valid; i++) step();
      chk("R2 out_valid before take", 64'(out_valid), 64'd1);
      p = out_pkt;
      out_ready = 1'b1;
      step();
      out_ready = 1'b0;
   endtask

   task automatic send_in(input logic [PKT_W-1:0] p);
      in_valid = 1'b1; in_pkt = p;
      for (int i = 0; i < 50 && !in_ready; i++) step();
      step();
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R9 pending after reset", 64'(pending), 64'd0);
      chk("R7 host_ready after reset", 64'(host_ready), 64'd1);
      chk("R2 out idle after reset", 64'(out_valid), 64'd0);
   endtask

   task automatic t_basic();
      logic [DATA_W-1:0] d;
      logic [PKT_W-1:0] p;
      host_write(10'h005, 32'hA5A5_0001);
      host_read(10'h005, d);
      chk("R1 local write visible next cycle", 64'(d), 64'hA5A5_0001);
      chk("R2 local packet emitted", 64'(out_valid), 64'd1);
      chk("R2 packet format", 64'(out_pkt), 64'(mk(ME, 10'h005, 32'hA5A5_0001)));
      take_out(p);
      chk("R9 pending after handoff", 64'(pending), 64'd1);
      send_in(p);
      chk("R4 own packet not forwarded", 64'(out_valid), 64'd0);
      chk("R9 pending after return", 64'(pending), 64'd0);
      host_read(10'h005, d);
      chk("R4 own return leaves RAM", 64'(d), 64'hA5A5_0001);
   endtask

   task automatic t_foreign();
      logic [DATA_W-1:0] d;
      logic [PKT_W-1:0] p;
      send_in(mk(4'h3, 10'h020, 32'hBEEF_0020));
      chk("R3 foreign forwarded", 64'(out_valid), 64'd1);
      chk("R3 foreign unchanged", 64'(out_pkt), 64'(mk(4'h3, 10'h020, 32'hBEEF_0020)));
      host_read(10'h020, d);
      chk("R3 foreign written locally", 64'(d), 64'hBEEF_0020);
      take_out(p);
      chk("R9 foreign not counted", 64'(pending), 64'd0);
   endtask

   task automatic t_reads();
      logic [DATA_W-1:0] d;
      int seen = 0;
      for (int i = 0; i < 4; i++) begin
         host_read(10'h020, d);
         if (out_valid) seen++;
      end
      chk("R5 reads stay local", 64'(seen), 64'd0);
      chk("R5 read data", 64'(d), 64'hBEEF_0020);
   endtask

   task automatic t_priority();
      logic [PKT_W-1:0] p;
      host_write(10'h007, 32'h7777_0007);
      step();
      host_write(10'h008, 32'h8888_0008);
      in_valid = 1'b1; in_pkt = mk(4'h2, 10'h030, 32'hF0F0_0030);
      chk("R6 stalled link refuses foreign", 64'(in_ready), 64'd0);
      out_ready = 1'b1;
      step();
      out_ready = 1'b0; in_valid = 1'b0;
      chk("R6 forward wins over queue", 64'(out_pkt), 64'(mk(4'h2, 10'h030, 32'hF0F0_0030)));
      chk("R9 pending one sent", 64'(pending), 64'd1);
      take_out(p);
      take_out(p);
      chk("R6 queued local follows", 64'(p), 64'(mk(ME, 10'h008, 32'h8888_0008)));
      chk("R9 pending two sent", 64'(pending), 64'd2);
      send_in(mk(ME, 10'h007, 32'h7777_0007));
      send_in(mk(ME, 10'h008, 32'h8888_0008));
      chk("R9 pending drained", 64'(pending), 64'd0);
   endtask

   task automatic t_full();
      logic [PKT_W-1:0] p;
      logic [DATA_W-1:0] d;
      int acc = 0, bad = 0;
      for (int i = 0; i < 12; i++) begin
         host_en = 1'b1; host_we = 1'b1;
         host_addr = 10'(10'h100 + acc); host_wdata = 32'(32'hC000_0000 + acc);
         if (host_ready) acc++;
         step();
      end
      host_en = 1'b0; host_we = 1'b0;
      chk("R7 nine writes accepted", 64'(acc), 64'd9);
      chk("R7 host stalled when full", 64'(host_ready), 64'd0);
      host_read(10'h108, d);
      chk("R1 stalled ring still writes RAM", 64'(d), 64'hC000_0008);
      for (int i = 0; i < 9; i++) begin
         take_out(p);
         if (p !== mk(ME, 10'(10'h100 + i), 32'(32'hC000_0000 + i))) bad++;
      end
      chk("R2 local order kept", 64'(bad), 64'd0);
      chk("R9 pending nine", 64'(pending), 64'd9);
      for (int i = 0; i < 9; i++) send_in(mk(ME, 10'(10'h100 + i), 32'(32'hC000_0000 + i)));
      chk("R9 pending back to zero", 64'(pending), 64'd0);
   endtask

   task automatic t_collide();
      logic [DATA_W-1:0] d;
      logic [PKT_W-1:0] p;
      host_en = 1'b1; host_we = 1'b1; host_addr = 10'h040; host_wdata = 32'h1111_4040;
      in_valid = 1'b1; in_pkt = mk(4'h9, 10'h040, 32'h9999_4040);
      step();
      host_en = 1'b0; host_we = 1'b0; in_valid = 1'b0;
      chk("R8 host blocked after collision", 64'(host_ready), 64'd0);
      step();
      chk("R8 host free again", 64'(host_ready), 64'd1);
      host_read(10'h040, d);
      chk("R8 host write applied last", 64'(d), 64'h1111_4040);
      take_out(p);
      chk("R8 foreign forwarded", 64'(p), 64'(mk(4'h9, 10'h040, 32'h9999_4040)));
      take_out(p);
      chk("R8 host packet sent", 64'(p), 64'(mk(ME, 10'h040, 32'h1111_4040)));
      send_in(p);
      chk("R9 collision pending zero", 64'(pending), 64'd0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      #1;
      t_reset();
      t_basic();
      t_foreign();
      t_reads();
      t_priority();
      t_full();
      t_collide();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule